// File: doc/BRIEF.md
# Partitioned Throttle Switch with Transition Log

Front-end and readout elements raise a throttle line when their buffers fill up. This block collects those throttle lines and sends each one back to the readout supervisor that runs the partition owning the congested element. Every input channel has a partition number and an enable bit, both set at run time through a small configuration port. Each partition output is the OR of the synchronized throttles of all enabled inputs assigned to it. The number of partitions is a parameter that must be 16 or 32, and elaboration stops on any other value. A system uses two identical instances, one for first-level throttles and one for second-level throttles.

Every change of the partition output vector is logged. Each log entry holds the new vector and the value of a free-running 32-bit cycle counter, and is stored in a 64-entry queue that software drains. A sticky overflow flag marks entries lost while the queue was full. A sticky per-input flag records which sources have asserted their throttle since software last cleared that flag.

Top module: `throttle_switch`

## Requirements
- R1: After reset all partition outputs are 0, all inputs are disabled and assigned to partition 0, the log is empty (`log_valid` = 0), `log_ovf` = 0 and all `seen` bits are 0.
- R2: A change on an enabled input, applied before clock edge k, appears on the output of that input's partition after edge k+3 and not before (two synchronizer stages plus one output register).
- R3: A partition output is the OR of the synchronized throttles of all enabled inputs assigned to it. It stays high while any one of them is high.
- R4: A disabled input never affects any partition output and causes no log entry.
- R5: A configuration write (`cfg_we` = 1, with `cfg_idx`, `cfg_en` and `cfg_part`) sampled at edge E changes the routing, so an asserted throttle moves to the new partition output after edge E+1.
- R6: Each clock edge on which the output vector changes writes one log entry with the new vector in `log_vec` (bit p = partition p) and the timestamp in `log_ts`. The timestamp counts up by one per clock, so the stamps of two entries differ by the number of cycles between the two output changes.
- R7: The log is first-word-fall-through: when `log_valid` = 1, `log_ts` and `log_vec` show the oldest entry, and `log_rd` = 1 at a clock edge removes it. Entries come out in order of writing.
- R8: The log holds 64 entries. A change that occurs while the log is full is dropped and sets `log_ovf`. `log_ovf` stays set until a clock edge with `log_rd` = 1 clears it. If a drop happens on the same edge, the set wins.
- R9: `seen[i]` is set once the synchronized input i is high, whether or not input i is enabled. It stays set until a clock edge with `seen_clr[i]` = 1 clears it. If the input is still high on that edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_in | input | N_IN | Asynchronous throttle inputs, one bit per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Input channel selected by the write |
| cfg_en | input | 1 | Enable value to store for the channel |
| cfg_part | input | PART_W | Partition number to store for the channel |
| thr_out | output | N_PART | Combined throttle, one bit per partition/supervisor |
| seen | output | N_IN | Sticky flags: input has asserted its throttle |
| seen_clr | input | N_IN | Per-input clear for the seen flags |
| log_rd | input | 1 | Remove the oldest log entry |
| log_valid | output | 1 | Log holds at least one entry |
| log_ts | output | 32 | Timestamp of the oldest entry |
| log_vec | output | N_PART | Output vector of the oldest entry |
| log_ovf | output | 1 | Sticky flag: log entries were dropped |

## Verification
The assertions check the following on every cycle: the log occupancy never exceeds its depth, a change that arrives while the log is full leaves the occupancy unchanged, the overflow flag and the seen flags do not clear without their clear inputs, every change of the partition vector comes with a log write request, and no output is high while all inputs are disabled. Some properties need a known stimulus history, and only the directed scenarios can show them: the exact three-cycle latency, OR combining, the effect of rerouting at run time, the spacing between timestamps, the order in which entries leave the log, and which entries are kept when the log overflows.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
   localparam int TS_W = 32;
   typedef logic [TS_W-1:0] ts_t;
endpackage

// File: rtl/tsw_sync.sv
module tsw_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tsw_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tsw_route.sv
module tsw_route #(
   parameter int N_IN   = 8,
   parameter int N_PART = 16,
   localparam int IDX_W  = (N_IN > 1) ? $clog2(N_IN) : 1,
   localparam int PART_W = $clog2(N_PART)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IN-1:0]   thr_sync,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_en,
   input  logic [PART_W-1:0] cfg_part,
   output logic [N_PART-1:0] out_d,
   output logic [N_PART-1:0] out_q
);
   logic [N_IN-1:0]   en_q;
   logic [PART_W-1:0] part_q [N_IN];

   for (genvar i = 0; i < N_IN; i++) begin : g_cfg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q[i]   <= 1'b0;
            part_q[i] <= '0;
         end else if (cfg_we && (int'(cfg_idx) == i)) begin
            en_q[i]   <= cfg_en;
            part_q[i] <= cfg_part;
         end
      end
   end

   for (genvar p = 0; p < N_PART; p++) begin : g_part
      always_comb begin
         out_d[p] = 1'b0;
         for (int i = 0; i < N_IN; i++) begin
            if (en_q[i] && thr_sync[i] && (int'(part_q[i]) == p)) out_d[p] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= out_d;
   end

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |=> (out_q == '0)); // R4
endmodule

// File: rtl/tsw_log.sv
module tsw_log
   import tsw_pkg::*;
#(
   parameter int N_PART = 16,
   parameter int DEPTH  = 64,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1,
   localparam int ENT_W = TS_W + N_PART
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PART-1:0] vec_next,
   input  logic [N_PART-1:0] vec_cur,
   input  logic              rd,
   output logic              valid,
   output ts_t               ts_o,
   output logic [N_PART-1:0] vec_o,
   output logic              ovf,
   output logic              push_req
);
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("tsw_log depth must be a power of two of at least 2");
   end

   ts_t              ts_q;
   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic [CNT_W-1:0] cnt;
   logic             full, push, pop;

   assign push_req = (vec_next != vec_cur);
   assign full     = (cnt == CNT_W'(DEPTH));
   assign push     = push_req && !full;
   assign pop      = rd && (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) ts_q <= '0;
      else        ts_q <= ts_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= {ts_q, vec_next};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (push_req && full) ovf <= 1'b1;
         else if (rd)          ovf <= 1'b0;
      end
   end

   assign valid = (cnt != '0);
   assign {ts_o, vec_o} = mem[rp];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH)); // R8
   AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full && !rd) |=> $stable(cnt)); // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ovf) && !$past(rd)) |-> ovf); // R8
endmodule

// File: rtl/throttle_switch.sv
module throttle_switch
   import tsw_pkg::*;
#(
   parameter int N_IN      = 8,
   parameter int N_PART    = 16,
   parameter int LOG_DEPTH = 64,
   parameter int SYNC_LEN  = 2,
   localparam int IDX_W  = (N_IN > 1) ? $clog2(N_IN) : 1,
   localparam int PART_W = $clog2(N_PART)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IN-1:0]   thr_in,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_en,
   input  logic [PART_W-1:0] cfg_part,
   output logic [N_PART-1:0] thr_out,
   output logic [N_IN-1:0]   seen,
   input  logic [N_IN-1:0]   seen_clr,
   input  logic              log_rd,
   output logic              log_valid,
   output logic [31:0]       log_ts,
   output logic [N_PART-1:0] log_vec,
   output logic              log_ovf
);
   if ((N_PART != 16) && (N_PART != 32)) begin : g_bad_part
      $error("throttle_switch supports 16 or 32 partitions only");
   end
   if (N_IN < 1) begin : g_bad_in
      $error("throttle_switch needs at least one input");
   end

   logic [N_IN-1:0]   thr_sync;
   logic [N_PART-1:0] out_d;
   logic              push_req;
   ts_t               ts_w;

   tsw_sync #(.WIDTH(N_IN), .STAGES(SYNC_LEN)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (thr_in),
      .q     (thr_sync)
   );

   tsw_route #(.N_IN(N_IN), .N_PART(N_PART)) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .thr_sync (thr_sync),
      .cfg_we   (cfg_we),
      .cfg_idx  (cfg_idx),
      .cfg_en   (cfg_en),
      .cfg_part (cfg_part),
      .out_d    (out_d),
      .out_q    (thr_out)
   );

   tsw_log #(.N_PART(N_PART), .DEPTH(LOG_DEPTH)) u_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .vec_next (out_d),
      .vec_cur  (thr_out),
      .rd       (log_rd),
      .valid    (log_valid),
      .ts_o     (ts_w),
      .vec_o    (log_vec),
      .ovf      (log_ovf),
      .push_req (push_req)
   );

   assign log_ts = ts_w;

   always_ff @(posedge clk) begin
      if (!rst_n) seen <= '0;
      else        seen <= (seen & ~seen_clr) | thr_sync;
   end

   AST_LOG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_out != $past(thr_out)) |-> $past(push_req)); // R6
   AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(seen) & ~$past(seen_clr) & ~seen) == '0)); // R9
endmodule

// File: tb/sim_throttle_switch.sv
module sim_throttle_switch;
   localparam int CLK_PERIOD = 10;
   localparam int NI = 8;
   localparam int NP = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] thr_in = '0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_idx = '0;
   logic          cfg_en = 1'b0;
   logic [3:0]    cfg_part = '0;
   logic [NP-1:0] thr_out;
   logic [NI-1:0] seen;
   logic [NI-1:0] seen_clr = '0;
   logic          log_rd = 1'b0;
   logic          log_valid;
   logic [31:0]   log_ts;
   logic [NP-1:0] log_vec;
   logic          log_ovf;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   throttle_switch #(.N_IN(NI), .N_PART(NP)) u0 (
      .clk(clk), .rst_n(rst_n), .thr_in(thr_in),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_part(cfg_part),
      .thr_out(thr_out), .seen(seen), .seen_clr(seen_clr),
      .log_rd(log_rd), .log_valid(log_valid), .log_ts(log_ts),
      .log_vec(log_vec), .log_ovf(log_ovf)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic cfg(input int idx, input logic en, input int part);
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_en = en; cfg_part = 4'(part);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pop();
      log_rd = 1'b1;
      @(negedge clk);
      log_rd = 1'b0;
   endtask

   task automatic drain();
      for (int k = 0; k < 100 && log_valid; k++) pop();
   endtask

   task automatic t_reset();
      chk("R1 thr_out", 64'(thr_out), 0);
      chk("R1 log_valid", 64'(log_valid), 0);
      chk("R1 log_ovf", 64'(log_ovf), 0);
      chk("R1 seen", 64'(seen), 0);
      thr_in = 8'hFF;          // all disabled after reset
      cyc(5);
      chk("R1 inputs disabled", 64'(thr_out), 0);
      thr_in = '0;
      cyc(4);
      seen_clr = '1; cyc(1); seen_clr = '0;
      drain();
   endtask

   task automatic t_latency();
      cfg(0, 1'b1, 3);
      thr_in[0] = 1'b1;
      cyc(2);
      chk("R2 not before 3 edges", 64'(thr_out), 0);
      cyc(1);
      chk("R2 after 3 edges", 64'(thr_out), 64'(16'h0008));
      thr_in[0] = 1'b0;
      cyc(2);
      chk("R2 fall not early", 64'(thr_out), 64'(16'h0008));
      cyc(1);
      chk("R2 fall after 3", 64'(thr_out), 0);
   endtask

   task automatic t_or();
      cfg(1, 1'b1, 5);
      cfg(2, 1'b1, 5);
      thr_in[1] = 1'b1;
      cyc(4);
      chk("R3 one source", 64'(thr_out[5]), 1);
      thr_in[2] = 1'b1; cyc(1); thr_in[1] = 1'b0;
      cyc(5);
      chk("R3 other source holds", 64'(thr_out[5]), 1);
      thr_in[2] = 1'b0;
      cyc(4);
      chk("R3 none", 64'(thr_out), 0);
   endtask

   task automatic t_disabled();
      drain();
      cfg(3, 1'b0, 7);
      thr_in[3] = 1'b1;
      cyc(6);
      chk("R4 disabled output", 64'(thr_out), 0);
      chk("R4 disabled no log", 64'(log_valid), 0);
      thr_in[3] = 1'b0;
      cyc(3);
   endtask

   task automatic t_reassign();
      cfg(4, 1'b1, 2);
      thr_in[4] = 1'b1;
      cyc(4);
      chk("R5 first route", 64'(thr_out), 64'(16'h0004));
      cfg_we = 1'b1; cfg_idx = 3'd4; cfg_en = 1'b1; cfg_part = 4'd9;
      @(negedge clk);          // sampled at edge E
      cfg_we = 1'b0;
      chk("R5 old route until E+1", 64'(thr_out), 64'(16'h0004));
      cyc(1);
      chk("R5 new route after E+1", 64'(thr_out), 64'(16'h0200));
      thr_in[4] = 1'b0;
      cyc(4);
   endtask

   task automatic t_log();
      logic [31:0] t0;
      drain();
      cfg(0, 1'b1, 11);
      thr_in[0] = 1'b1;
      cyc(5);
      thr_in[0] = 1'b0;
      cyc(5);
      chk("R7 valid", 64'(log_valid), 1);
      chk("R6 first vec", 64'(log_vec), 64'(16'h0800));
      t0 = log_ts;
      pop();
      chk("R7 second entry", 64'(log_valid), 1);
      chk("R6 second vec", 64'(log_vec), 0);
      chk("R6 stamp spacing", 64'(log_ts - t0), 5);
      pop();
      chk("R7 empty after pops", 64'(log_valid), 0);
   endtask

   task automatic t_overflow();
      int n;
      drain();
      for (int k = 0; k < 70; k++) begin
         thr_in[0] = ~thr_in[0];
         cyc(1);
      end
      thr_in[0] = 1'b0;   // after 70 toggles level is already 0
      cyc(5);
      chk("R8 ovf set", 64'(log_ovf), 1);
      chk("R8 first kept vec", 64'(log_vec), 64'(16'h0800));
      n = 0;
      pop();
      n++;
      chk("R8 ovf cleared by read", 64'(log_ovf), 0);
      while (log_valid && n < 100) begin
         pop();
         n++;
      end
      chk("R8 entries kept", 64'(n), 64);
   endtask

   task automatic t_seen();
      cfg(6, 1'b0, 1);
      seen_clr = '1; cyc(1); seen_clr = '0;
      thr_in[6] = 1'b1;
      cyc(4);
      chk("R9 set while disabled", 64'(seen), 64'(8'h40));
      seen_clr[6] = 1'b1; cyc(1); seen_clr[6] = 1'b0;
      chk("R9 set wins over clear", 64'(seen[6]), 1);
      thr_in[6] = 1'b0;
      cyc(4);
      chk("R9 sticky", 64'(seen[6]), 1);
      seen_clr[6] = 1'b1; cyc(1); seen_clr[6] = 1'b0;
      chk("R9 cleared", 64'(seen), 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_latency();
      t_or();
      t_disabled();
      t_reassign();
      t_log();
      t_overflow();
      t_seen();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule